// File: doc/BRIEF.md
# Fault Injection Scheduler

This block drives a campaign of faults through an emulated design under test. A fixed list of faults is configured by parameters. For each fault it gives a delay before activation, an injection length and a total slot length. When started, the scheduler walks the list from fault 0 upward, one fault per slot. Within a slot it first waits the activation delay. It then holds that fault's injection line at 1 for the injection length. It then keeps every line at 0 for the rest of the slot, so the effect of the fault can propagate and be captured before the next fault begins.

The injection lines form one wide vector with one bit per possible fault. The vector is routed to every fault site, and each site uses only its own bit. The scheduler also exports the index of the fault whose slot is running, a flag that is high while any line is driven, and busy/done status. All pins are plain control and status signals. There is no data stream, so no valid/ready handshake is involved.

Each slot must satisfy delay + injection length < slot length, and the injection length must be at least 1. Lines are decoded from registered state, so a fault site sees its line in the same cycle in which `fault_id` and `inject_on` report it.

Top module: `fis_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `fis_vec` is all zero, `inject_on`, `busy` and `done` are 0, and `fault_id` is 0. A reset in the middle of a run returns the block to this state.
- R2: When `start` is sampled high while the block is idle, `busy` is 1 and `fault_id` is 0 in the next cycle. That cycle is offset 0 of the run.
- R3: The line of fault i (bit i of `fis_vec`) first goes high at run offset S(i) + DLY(i). Here S(i) is the sum of the slot lengths of faults 0..i-1.
- R4: The line of fault i stays high for exactly HIGH(i) consecutive cycles and is 0 for the rest of its slot.
- R5: The slot of fault i lasts SLOT(i) cycles. `fault_id` equals i throughout that slot and changes to i+1 at offset S(i+1).
- R6: Only faults 0..NUM_FAULTS-1 are scheduled. Bits NUM_FAULTS and above of `fis_vec` never go high.
- R7: At most one bit of `fis_vec` is high in any cycle. All bits are 0 outside injection windows, while idle and after completion.
- R8: In the cycle after the last cycle of the last slot, `busy` is 0 and `done` is 1. `done` stays 1 until a new start is sampled.
- R9: A `start` sampled while `busy` is 1 has no effect on the schedule, on `fault_id` or on `fis_vec`.
- R10: A `start` sampled while `done` is 1 clears `done` and replays the whole sequence from fault 0 with the same timing.
- R11: `inject_on` is 1 exactly in the cycles in which some bit of `fis_vec` is 1. In those cycles that bit is bit `fault_id`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Synchronous request to begin the sequence at fault 0 |
| fis_vec | output | MAX_FAULTS | Injection lines, one per fault, at most one high |
| fault_id | output | $clog2(MAX_FAULTS) | Index of the fault whose slot is running |
| inject_on | output | 1 | High while the current fault's line is driven |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | All configured faults have been scheduled |

## Verification
A slot counter that is off by one moves every later rising and falling edge of `fis_vec`. It shifts the `fault_id` change points by the same amount, and this shows within the first slot and grows with each following fault. A wrong fault index or a bad line decode shows in the first injection cycle as the wrong bit or a second bit of `fis_vec`. A sequencer that fails to stop, or that accepts a restart while busy, shows as `done` missing or delayed, or as `fault_id` jumping back to 0 at the cycle after the stray start. The bench therefore compares the full vector, index and status on every cycle of each run.

// File: rtl/fis_pkg.sv
package fis_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/fis_param_rom.sv
module fis_param_rom #(
  parameter int          NUM_FAULTS = 4,
  parameter int          ID_W       = 6,
  parameter int          CNT_W      = 16,
  parameter int unsigned FLT_DLY  [NUM_FAULTS] = '{2, 0, 3, 1},
  parameter int unsigned FLT_HIGH [NUM_FAULTS] = '{3, 1, 2, 4},
  parameter int unsigned FLT_SLOT [NUM_FAULTS] = '{7, 3, 8, 6}
) (
  input  logic [ID_W-1:0]  idx,
  output logic [CNT_W-1:0] win_start,
  output logic [CNT_W-1:0] win_end,
  output logic [CNT_W-1:0] slot_last
);
  always_comb begin
    win_start = '0;
    win_end   = '0;
    slot_last = '0;
    for (int i = 0; i < NUM_FAULTS; i++) begin
      if (idx == ID_W'(i)) begin
        win_start = CNT_W'(FLT_DLY[i]);
        win_end   = CNT_W'(FLT_DLY[i] + FLT_HIGH[i]);
        slot_last = CNT_W'(FLT_SLOT[i] - 1);
      end
    end
  end
endmodule

// File: rtl/fis_slot_timer.sv
module fis_slot_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] win_start,
  input  logic [CNT_W-1:0] win_end,
  input  logic [CNT_W-1:0] slot_last,
  output logic             slot_end,
  output logic             in_win
);
  logic [CNT_W-1:0] cnt_q;

  assign slot_end = run && (cnt_q == slot_last);
  assign in_win   = run && (cnt_q >= win_start) && (cnt_q < win_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || slot_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fis_sequencer.sv
module fis_sequencer
  import fis_pkg::*;
#(
  parameter int NUM_FAULTS = 4,
  parameter int ID_W       = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            slot_end,
  output logic            run,
  output logic            done,
  output logic [ID_W-1:0] idx
);
  localparam logic [ID_W-1:0] LAST_IDX = ID_W'(NUM_FAULTS - 1);

  seq_state_e      state_q, state_d;
  logic [ID_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      SEQ_IDLE, SEQ_DONE: begin
        if (start) begin
          state_d = SEQ_RUN;
          idx_d   = '0;
        end
      end
      SEQ_RUN: begin
        if (slot_end) begin
          if (idx_q == LAST_IDX) begin
            state_d = SEQ_DONE;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign run  = (state_q == SEQ_RUN);
  assign done = (state_q == SEQ_DONE);
  assign idx  = idx_q;
endmodule

// File: rtl/fis_line_decoder.sv
module fis_line_decoder #(
  parameter int MAX_FAULTS = 64,
  parameter int NUM_FAULTS = 4,
  parameter int ID_W       = 6
) (
  input  logic                  en,
  input  logic [ID_W-1:0]       idx,
  output logic [MAX_FAULTS-1:0] lines
);
  for (genvar g = 0; g < MAX_FAULTS; g++) begin : g_line
    if (g < NUM_FAULTS) begin : g_used
      assign lines[g] = en && (idx == ID_W'(g));
    end else begin : g_unused
      assign lines[g] = 1'b0;
    end
  end
endmodule

// File: rtl/fis_sched.sv
module fis_sched #(
  parameter int          MAX_FAULTS = 64,
  parameter int          NUM_FAULTS = 4,
  parameter int          CNT_W      = 16,
  parameter int unsigned FLT_DLY  [NUM_FAULTS] = '{2, 0, 3, 1},
  parameter int unsigned FLT_HIGH [NUM_FAULTS] = '{3, 1, 2, 4},
  parameter int unsigned FLT_SLOT [NUM_FAULTS] = '{7, 3, 8, 6},
  localparam int         ID_W = $clog2(MAX_FAULTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  output logic [MAX_FAULTS-1:0] fis_vec,
  output logic [ID_W-1:0]       fault_id,
  output logic                  inject_on,
  output logic                  busy,
  output logic                  done
);
  logic             run;
  logic             slot_end;
  logic             in_win;
  logic [ID_W-1:0]  idx;
  logic [CNT_W-1:0] win_start, win_end, slot_last;

  fis_sequencer #(.NUM_FAULTS(NUM_FAULTS), .ID_W(ID_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .slot_end(slot_end),
    .run(run), .done(done), .idx(idx)
  );

  fis_param_rom #(
    .NUM_FAULTS(NUM_FAULTS), .ID_W(ID_W), .CNT_W(CNT_W),
    .FLT_DLY(FLT_DLY), .FLT_HIGH(FLT_HIGH), .FLT_SLOT(FLT_SLOT)
  ) u_rom (
    .idx(idx), .win_start(win_start), .win_end(win_end), .slot_last(slot_last)
  );

  fis_slot_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(run),
    .win_start(win_start), .win_end(win_end), .slot_last(slot_last),
    .slot_end(slot_end), .in_win(in_win)
  );

  fis_line_decoder #(.MAX_FAULTS(MAX_FAULTS), .NUM_FAULTS(NUM_FAULTS), .ID_W(ID_W)) u_dec (
    .en(in_win), .idx(idx), .lines(fis_vec)
  );

  assign fault_id  = idx;
  assign inject_on = in_win;
  assign busy      = run;
endmodule

// File: rtl/fis_sched_chk.sv
module fis_sched_chk #(
  parameter int MAX_FAULTS = 64,
  parameter int NUM_FAULTS = 4,
  parameter int ID_W       = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic [MAX_FAULTS-1:0] fis_vec,
  input logic [ID_W-1:0]       fault_id,
  input logic                  inject_on,
  input logic                  busy,
  input logic                  done
);
  AST_LINES_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fis_vec)); // R7

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (fis_vec == '0)); // R7

  AST_FLAG_MATCHES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    inject_on |-> fis_vec[fault_id]); // R11

  AST_FLAG_OFF_NO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !inject_on |-> (fis_vec == '0)); // R11

  AST_ID_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (fault_id < ID_W'(NUM_FAULTS))); // R6

  AST_ID_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |->
      (fault_id == $past(fault_id)) || (fault_id == $past(fault_id) + 1'b1)); // R9

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy) && ($past(fault_id) == ID_W'(NUM_FAULTS - 1))); // R8

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done); // R8

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R8

  AST_RESTART_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (fault_id == '0)); // R2
endmodule

bind fis_sched fis_sched_chk #(
  .MAX_FAULTS(MAX_FAULTS), .NUM_FAULTS(NUM_FAULTS), .ID_W(ID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .fis_vec(fis_vec),
  .fault_id(fault_id), .inject_on(inject_on), .busy(busy), .done(done)
);

// File: tb/sim_fis_sched.sv
`timescale 1ns/1ps
module sim_fis_sched;
  localparam int MAXF = 64;
  localparam int NF   = 4;
  localparam int IDW  = $clog2(MAXF);

  // Per-fault row: delay, injection length, slot length (R3 R4 R5)
  typedef struct packed {
    logic [7:0] dly;
    logic [7:0] hi;
    logic [7:0] slot;
  } row_t;
  localparam row_t TABLE [NF] = '{
    '{dly: 8'd2, hi: 8'd3, slot: 8'd7},
    '{dly: 8'd0, hi: 8'd1, slot: 8'd3},
    '{dly: 8'd3, hi: 8'd2, slot: 8'd8},
    '{dly: 8'd1, hi: 8'd4, slot: 8'd6}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [MAXF-1:0] fis_vec;
  logic [IDW-1:0]  fault_id;
  logic            inject_on, busy, done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fis_sched u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .fis_vec(fis_vec),
    .fault_id(fault_id), .inject_on(inject_on), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input logic [MAXF+IDW+2:0] act,
                     input logic [MAXF+IDW+2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual vec=%h id=%0d on=%b busy=%b done=%b expected vec=%h id=%0d on=%b busy=%b done=%b",
               req, act[MAXF+IDW+2:IDW+3], act[IDW+2:3], act[2], act[1], act[0],
               exp[MAXF+IDW+2:IDW+3], exp[IDW+2:3], exp[2], exp[1], exp[0]);
    end
  endtask

  function automatic logic [MAXF+IDW+2:0] pack_out(logic [MAXF-1:0] v, logic [IDW-1:0] id,
                                                   logic on, logic b, logic d);
    return {v, id, on, b, d};
  endfunction

  // Start sampled at a posedge, then walk every cycle of the run from offset 0.
  task automatic run_seq(input bit poke, input string tag);
    int t = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int f = 0; f < NF; f++) begin
      for (int c = 0; c < int'(TABLE[f].slot); c++) begin
        logic on;
        logic [MAXF-1:0] v;
        on = (c >= int'(TABLE[f].dly)) && (c < int'(TABLE[f].dly) + int'(TABLE[f].hi));
        v  = on ? (MAXF'(1) << f) : '0;
        chk({tag, " R3 R4 R5 R6 R7 R11 cycle"},
            pack_out(fis_vec, fault_id, inject_on, busy, done),
            pack_out(v, IDW'(f), on, 1'b1, 1'b0));
        // R9: stray start pulses while busy
        start = poke && (t == 4 || t == 15);
        t++;
        @(negedge clk);
      end
    end
    start = 1'b0;
    chk({tag, " R8 done"}, pack_out(fis_vec, fault_id, inject_on, busy, done),
        pack_out('0, IDW'(NF - 1), 1'b0, 1'b0, 1'b1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 in reset", pack_out(fis_vec, fault_id, inject_on, busy, done),
        pack_out('0, '0, 1'b0, 1'b0, 1'b0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", pack_out(fis_vec, fault_id, inject_on, busy, done),
        pack_out('0, '0, 1'b0, 1'b0, 1'b0));

    // R2 R3 R4 R5: first run, walked from the table
    run_seq(1'b0, "run1 R2");

    // R8: done holds without start
    repeat (3) @(negedge clk);
    chk("R8 done held", pack_out(fis_vec, fault_id, inject_on, busy, done),
        pack_out('0, IDW'(NF - 1), 1'b0, 1'b0, 1'b1));

    // R10 + R9: restart from done with stray starts during the run
    run_seq(1'b1, "run2 R10 R9");

    // R1: reset in the middle of a run
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 mid-run line high", {63'd0, fis_vec[0]}, {63'd0, 1'b1});
    rst_n = 1'b0;
    #1;
    chk("R1 mid-run reset", pack_out(fis_vec, fault_id, inject_on, busy, done),
        pack_out('0, '0, 1'b0, 1'b0, 1'b0));
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", pack_out(fis_vec, fault_id, inject_on, busy, done),
        pack_out('0, '0, 1'b0, 1'b0, 1'b0));

    // R2: start from idle after reset replays the sequence
    run_seq(1'b0, "run3 R2");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule